// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block takes a set of asynchronous, active-low interrupt pins and turns them into clean, prioritized requests for a processor core. Each pin passes through a two-stage synchronizer. A per-source mode bit makes the source either level-sensitive or sensitive to a falling edge. In edge mode a latch keeps the request pending until the core acknowledges it. A 2-bit field per source either disables it or gives it one of three priority levels. One more field of the same kind enables a whole group of already-synchronous internal sources at once and sets their shared level.

Software reaches the configuration through a small register port: one write port and one combinational read port. Each source has a register holding its priority field, its mode bit and a read-only status bit. What the status bit shows depends on the configuration. In edge mode with the source enabled, it shows the edge latch. In every other case it shows the synchronized pin level.

Each source is controlled by a four-state machine:
- `ST_OFF`: the source is disabled.
- `ST_LVL`: the source is enabled and level-triggered.
- `ST_ARMED`: the source is edge-triggered and waiting for an edge.
- `ST_PEND`: an edge has been latched.

The transitions between these states are:
- to_off: the field becomes 00, from any state.
- to_level: the source is enabled with the mode bit at 0, from any state.
- arm: the source is in edge mode while coming from `ST_OFF` or `ST_LVL`, or when an acknowledge arrives in `ST_PEND` with no new edge.
- capture: a falling edge is seen while the source is enabled in edge mode, from any state.
- hold: the state stays in `ST_PEND` when no acknowledge arrives.

Top module: `irq_cond`

## Requirements
- R1: After reset every priority field and mode bit is 0, `req` and `grp_req` are low, and a source register reads 8'h08 while its pin is high (status bit 3 shows the synchronized pin).
- R2: In level mode (register bit 2 = 0) with the source enabled, `req` goes high two clock edges after the pin goes low and falls two edges after it returns high. Status shows the synchronized pin.
- R3: Priority field bits [1:0]: 00 means disabled. 01, 10 and 11 drive `req_lvl` to 0, 1 and 2 while the source requests. `req_lvl` is 0 while the source does not request.
- R4: In edge mode (bit 2 = 1) with the source enabled, a falling pin edge sets the latch three edges after the pin change. Status then reads 1 and `req` is high.
- R5: An `ack` held for one cycle clears the latch at that edge, so status and `req` return to 0.
- R6: If a new falling edge is detected in the same cycle as `ack`, the latch stays set.
- R7: A disabled source never raises `req`, its status shows the synchronized pin, and edges seen while it is disabled are not latched.
- R8: Disabling a source, or changing its mode, clears its edge latch.
- R9: The status bit is read-only. Writing bit 3 has no effect on it.
- R10: Bits above 3 of a source register, bits above 1 of the group register, and every unmapped address all read as 0.
- R11: The group register (address NUM_SRC, bits [1:0]) gates `grp_req` = OR of `grp_src`, using the same level encoding on `grp_lvl`.
- R12: A rising pin edge in edge mode does not set the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | NUM_SRC | Asynchronous active-low interrupt pins |
| ack | input | NUM_SRC | Per-source service acknowledge from the core |
| grp_src | input | GRP_W | Synchronous active-high group sources |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address (0..NUM_SRC-1 sources, NUM_SRC group) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | DATA_W | Combinational read data |
| req | output | NUM_SRC | Per-source request to the core |
| req_lvl | output | 2*NUM_SRC | Per-source priority level, 2 bits each |
| grp_req | output | 1 | Group request |
| grp_lvl | output | 2 | Group priority level |

## Verification
The results become due at different cycles:
- A pin change reaches level-mode `req` and the synchronized status after two clock edges.
- A falling edge reaches the edge latch after three edges: two synchronizer stages, then the latch.
- Register writes and acknowledges take effect at the next edge.
- Group outputs and read data are combinational.

The bench drives inputs at the falling clock edge and advances an exact number of falling edges before it samples. Some checks sample one edge early on purpose, to confirm that a result has not appeared too soon. The same-cycle set/acknowledge case places `ack` in exactly the cycle where the synchronized sample falls.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
    typedef enum logic [1:0] {
        ST_OFF,
        ST_LVL,
        ST_ARMED,
        ST_PEND
    } src_state_e;

    function automatic logic [1:0] field_to_lvl(input logic [1:0] fld);
        return (fld == 2'b00) ? 2'b00 : fld - 2'b01;
    endfunction
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int  W       = 1,
    parameter logic RST_VAL = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= {W{RST_VAL}};
            q      <= {W{RST_VAL}};
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/irq_src_fsm.sv
module irq_src_fsm
    import irq_cond_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic edge_mode,
    input  logic fall,
    input  logic ack,
    output logic latched
);
    src_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_OFF;                       // to_off
        end else if (!edge_mode) begin
            state_d = ST_LVL;                       // to_level
        end else if (fall) begin
            state_d = ST_PEND;                      // capture (wins over ack)
        end else begin
            unique case (state_q)
                ST_OFF, ST_LVL: state_d = ST_ARMED; // arm, latch cleared
                ST_ARMED:       state_d = ST_ARMED;
                ST_PEND:        state_d = ack ? ST_ARMED : ST_PEND; // arm / hold
                default:        state_d = ST_OFF;
            endcase
        end
    end

    always_comb begin
        latched = (state_q == ST_PEND);
    end
endmodule

// File: rtl/irq_cond.sv
module irq_cond
    import irq_cond_pkg::*;
#(
    parameter int NUM_SRC = 2,
    parameter int GRP_W   = 3,
    parameter int DATA_W  = 8,
    parameter int ADDR_W  = $clog2(NUM_SRC + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_SRC-1:0]   irq_pin_n,
    input  logic [NUM_SRC-1:0]   ack,
    input  logic [GRP_W-1:0]     grp_src,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [DATA_W-1:0]    wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [DATA_W-1:0]    rd_data,
    output logic [NUM_SRC-1:0]   req,
    output logic [2*NUM_SRC-1:0] req_lvl,
    output logic                 grp_req,
    output logic [1:0]           grp_lvl
);
    localparam int MODE_BIT = 2;
    localparam int STAT_BIT = 3;
    localparam int CFG_W    = 3;
    localparam logic [ADDR_W-1:0] GRP_ADDR = ADDR_W'(NUM_SRC);

    logic [NUM_SRC-1:0][1:0] fld_q;
    logic [NUM_SRC-1:0]      mode_q;
    logic [1:0]              grp_fld_q;
    logic [NUM_SRC-1:0]      pin_s;
    logic [NUM_SRC-1:0]      pin_prev;
    logic [NUM_SRC-1:0]      fall;
    logic [NUM_SRC-1:0]      en;
    logic [NUM_SRC-1:0]      latched;
    logic [NUM_SRC-1:0]      status;
    logic                    grp_en;
    logic                    wr_unused;

    assign wr_unused = ^wr_data[DATA_W-1:CFG_W];

    // configuration write port; status and reserved bits are not stored
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fld_q     <= '0;
            mode_q    <= '0;
            grp_fld_q <= 2'b00;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (wr_addr == ADDR_W'(i)) begin
                    fld_q[i]  <= wr_data[1:0];
                    mode_q[i] <= wr_data[MODE_BIT];
                end
            end
            if (wr_addr == GRP_ADDR) grp_fld_q <= wr_data[1:0];
        end
    end

    irq_sync #(.W(NUM_SRC), .RST_VAL(1'b1)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (irq_pin_n),
        .q     (pin_s)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_prev <= '1;
        else        pin_prev <= pin_s;
    end

    assign fall = pin_prev & ~pin_s;

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        assign en[g] = (fld_q[g] != 2'b00);

        irq_src_fsm u_fsm (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (en[g]),
            .edge_mode (mode_q[g]),
            .fall      (fall[g]),
            .ack       (ack[g]),
            .latched   (latched[g])
        );

        always_comb begin
            if (en[g] && mode_q[g]) begin
                status[g] = latched[g];
                req[g]    = latched[g];
            end else begin
                status[g] = pin_s[g];
                req[g]    = en[g] && !pin_s[g];
            end
            req_lvl[2*g +: 2] = req[g] ? field_to_lvl(fld_q[g]) : 2'b00;
        end
    end

    assign grp_en  = (grp_fld_q != 2'b00);
    assign grp_req = grp_en && (|grp_src);
    assign grp_lvl = grp_req ? field_to_lvl(grp_fld_q) : 2'b00;

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (rd_addr == ADDR_W'(i)) begin
                rd_data[1:0]     = fld_q[i];
                rd_data[MODE_BIT] = mode_q[i];
                rd_data[STAT_BIT] = status[i];
            end
        end
        if (rd_addr == GRP_ADDR) rd_data[1:0] = grp_fld_q;
    end
endmodule

// File: rtl/irq_cond_chk.sv
module irq_cond_chk #(
    parameter int NUM_SRC = 2,
    parameter int GRP_W   = 3,
    parameter int DATA_W  = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_SRC-1:0]   en,
    input logic [NUM_SRC-1:0]   edge_mode,
    input logic [NUM_SRC-1:0]   fall,
    input logic [NUM_SRC-1:0]   ack,
    input logic [NUM_SRC-1:0]   latched,
    input logic [NUM_SRC-1:0]   req,
    input logic [2*NUM_SRC-1:0] req_lvl,
    input logic                 grp_req,
    input logic [GRP_W-1:0]     grp_src,
    input logic [DATA_W-1:0]    rd_data
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_chk
        AST_NO_REQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
            !en[g] |-> !req[g]);                                          // R7
        AST_LVL_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
            req[g] |-> (req_lvl[2*g +: 2] != 2'b11));                     // R3
        AST_EDGE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
            (en[g] && edge_mode[g] && fall[g]) |=> (latched[g] || !en[g] || !edge_mode[g])); // R4
        AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
            (en[g] && edge_mode[g] && fall[g] && ack[g]) |=> (latched[g] || !en[g] || !edge_mode[g])); // R6
        AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            (latched[g] && ack[g] && !fall[g]) |=> !latched[g]);          // R5
        AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
            !(en[g] && edge_mode[g]) |=> !latched[g]);                    // R8
    end

    AST_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[DATA_W-1:4] == '0);                                       // R10
    AST_GRP_NEEDS_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        grp_req |-> (grp_src != '0));                                     // R11
endmodule

bind irq_cond irq_cond_chk #(.NUM_SRC(NUM_SRC), .GRP_W(GRP_W), .DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (en),
    .edge_mode (mode_q),
    .fall      (fall),
    .ack       (ack),
    .latched   (latched),
    .req       (req),
    .req_lvl   (req_lvl),
    .grp_req   (grp_req),
    .grp_src   (grp_src),
    .rd_data   (rd_data)
);

// File: tb/irq_cond_tb.sv
`timescale 1ns/1ps
module irq_cond_tb;
    localparam int NUM_SRC = 2;
    localparam int GRP_W   = 3;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = $clog2(NUM_SRC + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NUM_SRC-1:0]   irq_pin_n = '1;
    logic [NUM_SRC-1:0]   ack = '0;
    logic [GRP_W-1:0]     grp_src = '0;
    logic                 wr_en = 1'b0;
    logic [ADDR_W-1:0]    wr_addr = '0;
    logic [DATA_W-1:0]    wr_data = '0;
    logic [ADDR_W-1:0]    rd_addr = '0;
    logic [DATA_W-1:0]    rd_data;
    logic [NUM_SRC-1:0]   req;
    logic [2*NUM_SRC-1:0] req_lvl;
    logic                 grp_req;
    logic [1:0]           grp_lvl;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    irq_cond #(.NUM_SRC(NUM_SRC), .GRP_W(GRP_W), .DATA_W(DATA_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .ack(ack), .grp_src(grp_src),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
        .rd_data(rd_data), .req(req), .req_lvl(req_lvl), .grp_req(grp_req), .grp_lvl(grp_lvl)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    function automatic logic [DATA_W-1:0] rd(input logic [ADDR_W-1:0] a);
        rd_addr = a;
        return rd_data;
    endfunction

    task automatic read_chk(input string tag, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] exp);
        rd_addr = a;
        #1;
        chk(tag, 32'(rd_data), 32'(exp));
    endtask

    task automatic pulse_ack();
        ack[0] = 1'b1; step(1); ack[0] = 1'b0;
    endtask

    task automatic t_reset();
        read_chk("R1 reset reg0", 0, 8'h08);
        read_chk("R1 reset grp", 2, 8'h00);
        chk("R1 reset req", 32'(req), 0);
        chk("R1 reset grp_req", 32'(grp_req), 0);
    endtask

    task automatic t_level();
        wr(0, 8'h01);
        irq_pin_n[0] = 1'b0;
        step(1);
        chk("R2 level req not yet", 32'(req[0]), 0);
        step(1);
        chk("R2 level req", 32'(req[0]), 1);
        chk("R3 lvl 01", 32'(req_lvl[1:0]), 0);
        read_chk("R2 level status low", 0, 8'h01);
        irq_pin_n[0] = 1'b1;
        step(2);
        chk("R2 level release", 32'(req[0]), 0);
        read_chk("R2 level status high", 0, 8'h09);
    endtask

    task automatic t_encoding();
        irq_pin_n[0] = 1'b0; step(2);
        wr(0, 8'h02);
        chk("R3 lvl 10", 32'(req_lvl[1:0]), 1);
        wr(0, 8'h03);
        chk("R3 lvl 11", 32'(req_lvl[1:0]), 2);
        wr(0, 8'h00);
        chk("R3 disabled req", 32'(req[0]), 0);
        chk("R3 disabled lvl", 32'(req_lvl[1:0]), 0);
        irq_pin_n[0] = 1'b1; step(3);
    endtask

    task automatic t_edge_ack();
        wr(0, 8'h05); step(1);
        irq_pin_n[0] = 1'b0;
        step(2);
        chk("R4 edge not yet", 32'(req[0]), 0);
        step(1);
        chk("R4 edge req", 32'(req[0]), 1);
        read_chk("R4 edge status", 0, 8'h0D);
        irq_pin_n[0] = 1'b1; step(3);
        chk("R4 latch holds", 32'(req[0]), 1);
        pulse_ack();
        chk("R5 ack clears req", 32'(req[0]), 0);
        read_chk("R5 ack clears status", 0, 8'h05);
    endtask

    task automatic t_set_wins();
        irq_pin_n[0] = 1'b0; step(3);
        irq_pin_n[0] = 1'b1; step(3);
        chk("R6 pending before", 32'(req[0]), 1);
        irq_pin_n[0] = 1'b0; step(2);
        pulse_ack();
        chk("R6 set beats ack", 32'(req[0]), 1);
        step(2);
        pulse_ack();
        chk("R6 later ack clears", 32'(req[0]), 0);
    endtask

    task automatic t_rising();
        irq_pin_n[0] = 1'b1; step(4);
        chk("R12 rising no req", 32'(req[0]), 0);
        read_chk("R12 rising status", 0, 8'h05);
    endtask

    task automatic t_disabled();
        wr(0, 8'h04);
        read_chk("R7 off status high", 0, 8'h0C);
        irq_pin_n[0] = 1'b0; step(2);
        chk("R7 off no req", 32'(req[0]), 0);
        read_chk("R7 off status pin", 0, 8'h04);
        irq_pin_n[0] = 1'b1; step(3);
        wr(0, 8'h05); step(1);
        chk("R7 edge while off not latched", 32'(req[0]), 0);
    endtask

    task automatic t_cfg_clear();
        irq_pin_n[0] = 1'b0; step(3);
        chk("R8 pending", 32'(req[0]), 1);
        wr(0, 8'h01);
        wr(0, 8'h05); step(1);
        chk("R8 mode switch clears", 32'(req[0]), 0);
        irq_pin_n[0] = 1'b1; step(3);
        irq_pin_n[0] = 1'b0; step(3);
        chk("R8 pending again", 32'(req[0]), 1);
        wr(0, 8'h00);
        wr(0, 8'h05); step(1);
        read_chk("R8 disable clears", 0, 8'h05);
        irq_pin_n[0] = 1'b1; step(3);
    endtask

    task automatic t_readonly();
        wr(0, 8'h0D); step(1);
        read_chk("R9 write status ignored", 0, 8'h05);
        chk("R9 no req", 32'(req[0]), 0);
        irq_pin_n[0] = 1'b0; step(3);
        wr(0, 8'h05); step(1);
        read_chk("R9 write 0 ignored", 0, 8'h0D);
        pulse_ack();
        irq_pin_n[0] = 1'b1; step(3);
    endtask

    task automatic t_reserved();
        wr(0, 8'hF1);
        read_chk("R10 src reserved", 0, 8'h09);
        wr(2, 8'hFE);
        read_chk("R10 grp reserved", 2, 8'h02);
        read_chk("R10 unmapped", 3, 8'h00);
        read_chk("R10 src1 idle", 1, 8'h08);
    endtask

    task automatic t_group();
        wr(2, 8'h03);
        grp_src = 3'b010; #1;
        chk("R11 grp req", 32'(grp_req), 1);
        chk("R11 grp lvl", 32'(grp_lvl), 2);
        grp_src = 3'b000; #1;
        chk("R11 grp idle", 32'(grp_req), 0);
        grp_src = 3'b100;
        wr(2, 8'h00); #1;
        chk("R11 grp disabled", 32'(grp_req), 0);
        grp_src = '0;
    endtask

    initial begin
        step(3);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_level();
        t_encoding();
        t_edge_ack();
        t_set_wins();
        t_rising();
        t_disabled();
        t_cfg_clear();
        t_readonly();
        t_reserved();
        t_group();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule